// File: doc/BRIEF.md
# Piecewise-linear ADC linearity corrector

This block removes a per-channel nonlinearity from 12-bit ADC samples. The correction curve is described by five signed knot values held at codes 0, 1000, 2000, 3000 and 4000. Each incoming code falls into one of four segments. The block weights the two knots that bound that segment according to where the code lies inside it. It adds the blended offset to the code and clamps the sum to the valid output range.

The knot values are fitted offline and written through a small register port before samples flow. They then stay fixed while a run of samples is processed. A write is still allowed during a run: samples that entered earlier keep the old curve, and later samples use the new one. Samples move through a three-stage pipeline, and a valid flag travels with each sample.

Top module: `adc_lin_corrector`

## Requirements
- R1: The segment index k is 0 for codes 0-999, 1 for 1000-1999, 2 for 2000-2999 and 3 for 3000-4095, so codes 4000-4095 extend segment 3 linearly past the knot at 4000.
- R2: The interpolation weight is w = floor(p*1024/1000), where p = code - 1000*k lies in 0..1095, and the result is exact for every p in that range.
- R3: Knot i belongs to code 1000*i and is a 12-bit two's-complement value with 4 fractional bits; the blended value, in units of 2^-14 code, is a = y_k*1024 + (y_(k+1) - y_k)*w, with no loss of precision before rounding.
- R4: The offset is floor((a + 8192) / 16384), which rounds to nearest with halves rounded upward, and the corrected code is the input code plus this offset.
- R5: The corrected code is clamped to 0 when the sum is negative and to 4095 when the sum is above 4095.
- R6: When kw_en is high and kw_sel is 0 to 4, the knot selected by kw_sel takes kw_data at that clock edge; knots do not change in any cycle where kw_en is low.
- R7: A write with kw_sel equal to 5, 6 or 7 changes no knot.
- R8: out_valid equals in_valid delayed by exactly three clock cycles, and out_code holds its last value while out_valid is low.
- R9: A sample presented in the same cycle as a knot write uses the knot values from before the write; every later sample uses the new values.
- R10: After reset all knots are zero, so the corrector passes codes through unchanged, and out_valid stays low until valid samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample qualifier |
| in_code | input | 12 | Measured ADC code |
| kw_en | input | 1 | Knot write strobe |
| kw_sel | input | 3 | Knot index, 0 to 4 are valid |
| kw_data | input | 12 | Knot value, signed, 4 fractional bits |
| out_valid | output | 1 | Corrected sample qualifier |
| out_code | output | 12 | Corrected, clamped code |

## Verification
The checker assumes that kw_en, kw_sel and kw_data are never unknown once the internal reset has been released. It also assumes that rst_n is applied for at least one clock edge. The latency property needs three clock cycles after reset before it applies. The bench waits longer than that after release before it sends any sample or write, and it drives every input on the falling edge. This keeps the knot-hold and write-capture properties inside their stated conditions.

// File: rtl/alc_pkg.sv
package alc_pkg;
  // default geometry of the corrector
  localparam int unsigned ALC_CODE_W      = 12;
  localparam int unsigned ALC_KNOT_W      = 12;
  localparam int unsigned ALC_KNOT_FRAC   = 4;
  localparam int unsigned ALC_NUM_SEG     = 4;
  localparam int unsigned ALC_SEG_SPAN    = 1000;
  localparam int unsigned ALC_WGT_FRAC    = 10;
  localparam int unsigned ALC_RECIP_SHIFT = 24;
endpackage

// File: rtl/alc_knot_file.sv
module alc_knot_file #(
  parameter int unsigned NUM_KNOTS = 5,
  parameter int unsigned KNOT_W    = 12,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [KNOT_W-1:0]                wr_data,
  output logic [NUM_KNOTS-1:0][KNOT_W-1:0] knots
);

  for (genvar gi = 0; gi < NUM_KNOTS; gi++) begin : g_knot
    logic              hit;
    logic [KNOT_W-1:0] q;

    always_comb begin
      hit = wr_en && (wr_sel == SEL_W'(gi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wr_data;
      end
    end

    assign knots[gi] = q;
  end

endmodule

// File: rtl/alc_stage_locate.sv
module alc_stage_locate #(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned KNOT_W   = 12,
  parameter int unsigned NUM_SEG  = 4,
  parameter int unsigned SEG_SPAN = 1000,
  parameter int unsigned SEG_W    = 2,
  parameter int unsigned POS_W    = 11
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [CODE_W-1:0]                in_code,
  input  logic [NUM_SEG:0][KNOT_W-1:0]     knots,
  output logic                             s1_valid,
  output logic [CODE_W-1:0]                s1_code,
  output logic [POS_W-1:0]                 s1_pos,
  output logic [KNOT_W-1:0]                s1_ylo,
  output logic [KNOT_W-1:0]                s1_yhi
);

  logic [NUM_SEG-2:0] above;
  logic [SEG_W-1:0]   seg;
  logic [CODE_W-1:0]  base;
  logic [POS_W-1:0]   pos_n;
  logic [KNOT_W-1:0]  ylo_n;
  logic [KNOT_W-1:0]  yhi_n;

  // one range compare per interior breakpoint
  for (genvar gb = 1; gb < NUM_SEG; gb++) begin : g_edge
    always_comb begin
      above[gb-1] = (in_code >= CODE_W'(gb * SEG_SPAN));
    end
  end

  // breakpoints rise monotonically, so the highest one passed names the segment
  always_comb begin
    seg  = '0;
    base = '0;
    for (int i = 1; i < NUM_SEG; i++) begin
      if (above[i-1]) begin
        seg  = SEG_W'(i);
        base = CODE_W'(i * SEG_SPAN);
      end
    end
    pos_n = POS_W'(in_code - base);
  end

  // pick the two bounding knots, snapshotted as the sample enters
  always_comb begin
    ylo_n = '0;
    yhi_n = '0;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (seg == SEG_W'(k)) begin
        ylo_n = knots[k];
        yhi_n = knots[k+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_code <= in_code;
      s1_pos  <= pos_n;
      s1_ylo  <= ylo_n;
      s1_yhi  <= yhi_n;
    end
  end

endmodule

// File: rtl/alc_stage_weight.sv
module alc_stage_weight #(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned KNOT_W      = 12,
  parameter int unsigned SEG_SPAN    = 1000,
  parameter int unsigned POS_W       = 11,
  parameter int unsigned WGT_W       = 11,
  parameter int unsigned WGT_FRAC    = 10,
  parameter int unsigned RECIP_SHIFT = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_valid,
  input  logic [CODE_W-1:0]   s1_code,
  input  logic [POS_W-1:0]    s1_pos,
  input  logic [KNOT_W-1:0]   s1_ylo,
  input  logic [KNOT_W-1:0]   s1_yhi,
  output logic                s2_valid,
  output logic [CODE_W-1:0]   s2_code,
  output logic [WGT_W-1:0]    s2_w,
  output logic [KNOT_W-1:0]   s2_ylo,
  output logic [KNOT_W:0]     s2_diff
);

  // reciprocal of the segment span, rounded up, scaled by the weight precision
  localparam longint unsigned RECIP_L =
    ((64'd1 << (RECIP_SHIFT + WGT_FRAC)) + 64'(SEG_SPAN) - 64'd1) / 64'(SEG_SPAN);
  localparam int unsigned RCP_W  = $clog2(RECIP_L + 1);
  localparam int unsigned PROD_W = POS_W + RCP_W;

  logic [PROD_W-1:0]        prod;
  logic [WGT_W-1:0]         w_n;
  logic signed [KNOT_W:0]   diff_n;

  always_comb begin
    prod   = PROD_W'(s1_pos) * PROD_W'(RECIP_L);
    w_n    = WGT_W'(prod >> RECIP_SHIFT);
    diff_n = $signed({s1_yhi[KNOT_W-1], s1_yhi}) - $signed({s1_ylo[KNOT_W-1], s1_ylo});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_code <= s1_code;
      s2_w    <= w_n;
      s2_ylo  <= s1_ylo;
      s2_diff <= diff_n;
    end
  end

endmodule

// File: rtl/alc_stage_blend.sv
module alc_stage_blend #(
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned KNOT_W    = 12,
  parameter int unsigned KNOT_FRAC = 4,
  parameter int unsigned WGT_W     = 11,
  parameter int unsigned WGT_FRAC  = 10,
  parameter int unsigned ACC_W     = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s2_valid,
  input  logic [CODE_W-1:0]   s2_code,
  input  logic [WGT_W-1:0]    s2_w,
  input  logic [KNOT_W-1:0]   s2_ylo,
  input  logic [KNOT_W:0]     s2_diff,
  output logic                out_valid,
  output logic [CODE_W-1:0]   out_code
);

  localparam int unsigned SH = KNOT_FRAC + WGT_FRAC;
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(64'd1 << (SH - 1));
  localparam logic signed [ACC_W-1:0] CEIL  = ACC_W'((64'd1 << CODE_W) - 64'd1);

  logic signed [ACC_W-1:0] base_v;
  logic signed [ACC_W-1:0] d_x;
  logic signed [ACC_W-1:0] w_x;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] off;
  logic signed [ACC_W-1:0] sum;
  logic [CODE_W-1:0]       code_n;

  always_comb begin
    base_v = $signed({{(ACC_W-KNOT_W){s2_ylo[KNOT_W-1]}}, s2_ylo}) <<< WGT_FRAC;
    d_x    = $signed({{(ACC_W-KNOT_W-1){s2_diff[KNOT_W]}}, s2_diff});
    w_x    = $signed({{(ACC_W-WGT_W){1'b0}}, s2_w});
    acc    = base_v + d_x * w_x;
    off    = (acc + HALF) >>> SH;
    sum    = off + $signed({{(ACC_W-CODE_W){1'b0}}, s2_code});
    if (sum < 0) begin
      code_n = '0;
    end else if (sum > CEIL) begin
      code_n = '1;
    end else begin
      code_n = CODE_W'(sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_code <= code_n;
    end
  end

endmodule

// File: rtl/adc_lin_corrector.sv
module adc_lin_corrector
  import alc_pkg::*;
#(
  parameter int unsigned CODE_W      = ALC_CODE_W,
  parameter int unsigned KNOT_W      = ALC_KNOT_W,
  parameter int unsigned KNOT_FRAC   = ALC_KNOT_FRAC,
  parameter int unsigned NUM_SEG     = ALC_NUM_SEG,
  parameter int unsigned SEG_SPAN    = ALC_SEG_SPAN,
  parameter int unsigned WGT_FRAC    = ALC_WGT_FRAC,
  parameter int unsigned RECIP_SHIFT = ALC_RECIP_SHIFT,
  parameter int unsigned SEL_W       = $clog2(NUM_SEG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              kw_en,
  input  logic [SEL_W-1:0]  kw_sel,
  input  logic [KNOT_W-1:0] kw_data,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code
);

  localparam int unsigned NUM_KNOTS = NUM_SEG + 1;
  localparam int unsigned SEG_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
  localparam int unsigned MAX_POS   = (1 << CODE_W) - 1 - (NUM_SEG - 1) * SEG_SPAN;
  localparam int unsigned POS_W     = $clog2(MAX_POS + 1);
  localparam int unsigned WGT_W     = $clog2(((MAX_POS << WGT_FRAC) / SEG_SPAN) + 1);
  localparam int unsigned ACC_W     = KNOT_W + WGT_W + 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_q_n = rst_pipe[1];

  logic [NUM_KNOTS-1:0][KNOT_W-1:0] knot_q;

  logic              s1_valid;
  logic [CODE_W-1:0] s1_code;
  logic [POS_W-1:0]  s1_pos;
  logic [KNOT_W-1:0] s1_ylo;
  logic [KNOT_W-1:0] s1_yhi;

  logic              s2_valid;
  logic [CODE_W-1:0] s2_code;
  logic [WGT_W-1:0]  s2_w;
  logic [KNOT_W-1:0] s2_ylo;
  logic [KNOT_W:0]   s2_diff;

  alc_knot_file #(
    .NUM_KNOTS (NUM_KNOTS),
    .KNOT_W    (KNOT_W),
    .SEL_W     (SEL_W)
  ) u_knots (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (kw_en),
    .wr_sel  (kw_sel),
    .wr_data (kw_data),
    .knots   (knot_q)
  );

  alc_stage_locate #(
    .CODE_W   (CODE_W),
    .KNOT_W   (KNOT_W),
    .NUM_SEG  (NUM_SEG),
    .SEG_SPAN (SEG_SPAN),
    .SEG_W    (SEG_W),
    .POS_W    (POS_W)
  ) u_locate (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .in_valid (in_valid),
    .in_code  (in_code),
    .knots    (knot_q),
    .s1_valid (s1_valid),
    .s1_code  (s1_code),
    .s1_pos   (s1_pos),
    .s1_ylo   (s1_ylo),
    .s1_yhi   (s1_yhi)
  );

  alc_stage_weight #(
    .CODE_W      (CODE_W),
    .KNOT_W      (KNOT_W),
    .SEG_SPAN    (SEG_SPAN),
    .POS_W       (POS_W),
    .WGT_W       (WGT_W),
    .WGT_FRAC    (WGT_FRAC),
    .RECIP_SHIFT (RECIP_SHIFT)
  ) u_weight (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .s1_valid (s1_valid),
    .s1_code  (s1_code),
    .s1_pos   (s1_pos),
    .s1_ylo   (s1_ylo),
    .s1_yhi   (s1_yhi),
    .s2_valid (s2_valid),
    .s2_code  (s2_code),
    .s2_w     (s2_w),
    .s2_ylo   (s2_ylo),
    .s2_diff  (s2_diff)
  );

  alc_stage_blend #(
    .CODE_W    (CODE_W),
    .KNOT_W    (KNOT_W),
    .KNOT_FRAC (KNOT_FRAC),
    .WGT_W     (WGT_W),
    .WGT_FRAC  (WGT_FRAC),
    .ACC_W     (ACC_W)
  ) u_blend (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .s2_valid  (s2_valid),
    .s2_code   (s2_code),
    .s2_w      (s2_w),
    .s2_ylo    (s2_ylo),
    .s2_diff   (s2_diff),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

endmodule

// File: rtl/alc_checker.sv
module alc_checker #(
  parameter int unsigned NUM_KNOTS = 5,
  parameter int unsigned KNOT_W    = 12,
  parameter int unsigned SEL_W     = 3
) (
  input logic                             clk,
  input logic                             rst_q_n,
  input logic                             in_valid,
  input logic                             out_valid,
  input logic                             kw_en,
  input logic [SEL_W-1:0]                 kw_sel,
  input logic [KNOT_W-1:0]                kw_data,
  input logic [NUM_KNOTS-1:0][KNOT_W-1:0] knots
);

  logic [1:0]        warm;
  logic              wr_seen;
  logic [SEL_W-1:0]  wr_sel_q;
  logic [KNOT_W-1:0] wr_data_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      warm    <= 2'd0;
      wr_seen <= 1'b0;
    end else begin
      if (warm != 2'd3) begin
        warm <= warm + 2'd1;
      end
      wr_seen <= kw_en && (kw_sel < SEL_W'(NUM_KNOTS));
    end
  end

  always_ff @(posedge clk) begin
    wr_sel_q  <= kw_sel;
    wr_data_q <= kw_data;
  end

  // R8: valid emerges exactly three cycles after it enters
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_q_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6: an accepted write lands in the addressed knot
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_seen |-> (knots[wr_sel_q] == wr_data_q));

  // R6: without a strobe the knots do not move
  a_r6_knots_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !kw_en |=> $stable(knots));

  // R7: an out-of-range index leaves every knot alone
  a_r7_bad_index: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kw_en && (kw_sel >= SEL_W'(NUM_KNOTS))) |=> $stable(knots));

endmodule

bind adc_lin_corrector alc_checker u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .kw_en     (kw_en),
  .kw_sel    (kw_sel),
  .kw_data   (kw_data),
  .knots     (knot_q)
);

// File: tb/adc_lin_corrector_bench.sv
module adc_lin_corrector_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_code;
  logic        kw_en;
  logic [2:0]  kw_sel;
  logic [11:0] kw_data;
  logic        out_valid;
  logic [11:0] out_code;

  int checks;
  int errors;
  int kn[5];
  bit hv[3];
  int hc[3];
  int last_out;
  bit have_last;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  adc_lin_corrector u_adc_lin_corrector (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .kw_en     (kw_en),
    .kw_sel    (kw_sel),
    .kw_data   (kw_data),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected corrected code from the requirements (R1..R5)
  function automatic int model(int b);
    int k, p, w, a, off, c;
    k = 0;
    if (b >= 1000) k = 1;
    if (b >= 2000) k = 2;
    if (b >= 3000) k = 3;
    p   = b - 1000 * k;
    w   = (p * 1024) / 1000;
    a   = kn[k] * 1024 + (kn[k+1] - kn[k]) * w;
    off = (a + 8192) >>> 14;
    c   = b + off;
    if (c < 0) c = 0;
    if (c > 4095) c = 4095;
    return c;
  endfunction

  // one cycle: compare the output, then drive new inputs
  task automatic step(bit v, int code, bit we, int sel, int data, string req);
    @(negedge clk);
    if (hv[2]) begin
      check(out_valid == 1'b1, "R8", int'(out_valid), 1);
      check(int'(out_code) == hc[2], req, int'(out_code), hc[2]);
      last_out  = hc[2];
      have_last = 1'b1;
    end else begin
      check(out_valid == 1'b0, "R8", int'(out_valid), 0);
      if (have_last) check(int'(out_code) == last_out, "R8", int'(out_code), last_out);
    end
    hv[2] = hv[1]; hc[2] = hc[1];
    hv[1] = hv[0]; hc[1] = hc[0];
    hv[0] = v;
    hc[0] = v ? model(code) : 0;
    in_valid = v;
    in_code  = 12'(code);
    kw_en    = we;
    kw_sel   = 3'(sel);
    kw_data  = 12'(data);
    if (we && sel < 5) kn[sel] = (data >= 2048) ? data - 4096 : data;
  endtask

  task automatic load(int a0, int a1, int a2, int a3, int a4);
    step(0, 0, 1, 0, a0 & 12'hfff, "R6");
    step(0, 0, 1, 1, a1 & 12'hfff, "R6");
    step(0, 0, 1, 2, a2 & 12'hfff, "R6");
    step(0, 0, 1, 3, a3 & 12'hfff, "R6");
    step(0, 0, 1, 4, a4 & 12'hfff, "R6");
  endtask

  task automatic sweep(string req, int gap);
    for (int c = 0; c < 4096; c++) begin
      if (gap != 0 && (c % gap) == 0) step(0, c, 0, 0, 0, req);
      step(1, c, 0, 0, 0, req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; have_last = 1'b0;
    for (int i = 0; i < 5; i++) kn[i] = 0;
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hc[i] = 0; end
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0;
    kw_en = 1'b0; kw_sel = '0; kw_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R10", int'(out_valid), 0);

    // R10: zero knots give identity
    sweep("R10", 0);

    // R3: general curve, fractional knots
    load(48, -73, 100, -37, 250);
    sweep("R3", 0);

    // R1: breakpoint codes and the extended top segment
    step(1, 999, 0, 0, 0, "R1");  step(1, 1000, 0, 0, 0, "R1");
    step(1, 1999, 0, 0, 0, "R1"); step(1, 2000, 0, 0, 0, "R1");
    step(1, 2999, 0, 0, 0, "R1"); step(1, 3000, 0, 0, 0, "R1");
    step(1, 4000, 0, 0, 0, "R1"); step(1, 4095, 0, 0, 0, "R1");

    // R2: largest slopes expose any weight truncation error
    load(-2048, 2047, -2048, 2047, -2048);
    sweep("R2", 0);

    // R5: clamp at both ends
    load(-2048, 0, 0, 2047, 2047);
    sweep("R5", 0);
    step(1, 0, 0, 0, 0, "R5");
    step(1, 4095, 0, 0, 0, "R5");

    // R4: half-code knots round upward
    load(8, -8, 24, -24, 7);
    step(1, 1000, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 2000, 0, 0, 0, "R4");
    step(1, 3000, 0, 0, 0, "R4");
    load(1, 3, -5, 9, -15);
    sweep("R4", 0);

    // R8: gaps in the valid stream, output held
    sweep("R8", 3);

    // R7: out-of-range indices are ignored
    step(0, 0, 1, 5, 12'h7ff, "R7");
    step(0, 0, 1, 6, 12'h800, "R7");
    step(0, 0, 1, 7, 12'h123, "R7");
    for (int c = 0; c < 4096; c += 250) step(1, c, 0, 0, 0, "R7");

    // R9: write in the same cycle as a sample, and while samples are in flight
    load(0, 0, 0, 0, 0);
    step(1, 500, 1, 0, 800, "R9");
    step(1, 500, 1, 1, 1600, "R9");
    step(1, 500, 0, 0, 0, "R9");
    step(1, 1000, 1, 1, 0, "R9");
    step(1, 1000, 0, 0, 0, "R9");

    // R6: each knot alone at its own code
    for (int i = 0; i < 5; i++) begin
      load(0, 0, 0, 0, 0);
      step(0, 0, 1, i, 320, "R6");
      step(1, (i == 4) ? 4000 : i * 1000, 0, 0, 0, "R6");
      step(1, 4095, 0, 0, 0, "R6");
    end

    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R8");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule